// File: doc/BRIEF.md
# NAND Flash Device-Side Bus Decoder

This block sits on the device side of an 8-bit asynchronous NAND flash bus. It is a behavioural target against which a host controller can be verified. All bus pins are sampled on a local clock. The three timing strobes (chip enable, write enable, read enable) are cleaned of short pulses first. Every accepted strobe edge then becomes one decoded event: a command, an address byte, a data-input byte or a data-output beat. Each event is a one-cycle pulse that carries the byte that was on the bus.

The decoder tracks the operation in progress. A command opens an address window of four or five bytes, depending on a density-mode pin. A program-setup command also opens a data-input phase once that window is full. Address or data bytes that arrive outside their phase raise an error pulse instead of an event.

Write protection is read live from its pin at every decision and is never held in a register. While it is low, modify commands and data bytes are refused and reported on a separate pulse.

Top module: `nand_bus_decoder`

## Requirements
- R1: On a filtered write-enable rising edge, with chip enable low and read enable high, command-latch high with address-latch low yields one `ev_cmd` pulse carrying the bus byte. Both latch enables high yields no event of any kind.
- R2: Address-latch high with command-latch low under the same strobe conditions yields `ev_addr` carrying the byte. `ev_addr_idx` gives the byte's position, starting at 0 after the last command.
- R3: With both latch enables low and write protect high, a write-enable rising edge inside an open data phase yields `ev_din` with the byte. Only program-setup codes 0x80 and 0x85 open that phase, and it opens once the full address count has been received.
- R4: A filtered read-enable rising edge with chip enable low, write enable high and both latch enables low yields one `ev_dout` pulse. `dout_oe` is high exactly while read enable is filtered low under those conditions. A read strobe with a latch enable high gives no `ev_dout`.
- R5: While write protect is low, a modify command (0x80, 0x85, 0x60, 0x10, 0xD0, 0x15) or a data-input byte produces `ev_wp_block` instead of its event. A blocked command closes any open operation. Non-modify commands are unaffected by write protect.
- R6: Write protect is taken at the decision edge itself. A low level that has already returned high has no effect, and a level that falls after the command still blocks later data.
- R7: A raw strobe level takes effect only after it has held for GLITCH_W consecutive sample clocks. A shorter pulse is dropped. An event appears GLITCH_W+1 clocks after the raw write-enable rise.
- R8: The address window is 4 bytes when `addr_5b` is 0 and 5 bytes when it is 1. An extra address byte produces `ev_phase_err` and no `ev_addr`.
- R9: While filtered chip enable is high, no event is produced and `dout_oe` is low.
- R10: Every accepted command resets the address counter, so the next address byte has index 0.
- R11: A data-input byte outside an open data phase (after a non-program command, or before the address window is full) produces `ev_phase_err` and no `ev_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte from the host |
| addr_5b | input | 1 | 1 selects a five-byte address window |
| ev_cmd | output | 1 | Command event pulse |
| ev_addr | output | 1 | Address event pulse |
| ev_din | output | 1 | Data-input event pulse |
| ev_dout | output | 1 | Data-output beat pulse |
| ev_byte | output | 8 | Byte carried by the current event |
| ev_addr_idx | output | 3 | Position of the address byte |
| ev_wp_block | output | 1 | Modify operation refused by write protect |
| ev_phase_err | output | 1 | Address or data byte out of phase |
| dout_oe | output | 1 | Data output driver enable |

## Verification
The hardest case to reach from the ports is a write-protect change that lands between a command and its data. It tests that protection is re-read rather than captured. The stimulus issues a program-setup command with protect high and fills the address window, then drops protect before a data strobe and raises it before the next. A second case pulses protect low and back high without any write strobe just before a modify command. The glitch path is reached with raw strobe pulses one sample shorter than the filter width, and with an exact cycle count of the delay from raw edge to event.

// File: rtl/nbd_pkg.sv
package nbd_pkg;

  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_CMD  = 3'd1,
    K_ADDR = 3'd2,
    K_DIN  = 3'd3,
    K_DOUT = 3'd4
  } cyc_kind_t;

  // commands that start or confirm a program or erase
  function automatic logic is_modify(input logic [7:0] code);
    return (code == 8'h80) || (code == 8'h85) || (code == 8'h60) ||
           (code == 8'h10) || (code == 8'hD0) || (code == 8'h15);
  endfunction

  // commands after which data bytes may be loaded
  function automatic logic opens_din(input logic [7:0] code);
    return (code == 8'h80) || (code == 8'h85);
  endfunction

  function automatic logic [IDX_W-1:0] addr_len(input logic five);
    return five ? IDX_W'(5) : IDX_W'(4);
  endfunction

endpackage

// File: rtl/nbd_deglitch.sv
module nbd_deglitch #(
  parameter int   MIN_W = 4,
  parameter logic INIT  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= INIT;
      run  <= '0;
    end else if (raw == filt) begin
      run <= '0;
    end else if (run == CW'(MIN_W - 1)) begin
      filt <= raw;
      run  <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  // a filtered change must follow a sample already at the new level
  assert_filter_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> $past(raw) == filt);

endmodule

// File: rtl/nbd_cycle_class.sv
module nbd_cycle_class
  import nbd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_f,
  input  logic      we_f,
  input  logic      re_f,
  input  logic      cle,
  input  logic      ale,
  output cyc_kind_t kind,
  output logic      we_rise,
  output logic      re_rise,
  output logic      dout_oe
);
  logic we_q, re_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_f;
      re_q <= re_f;
    end
  end

  assign we_rise = we_f & ~we_q;
  assign re_rise = re_f & ~re_q;
  assign dout_oe = ~ce_f & we_f & ~re_f & ~cle & ~ale;

  always_comb begin
    kind = K_NONE;
    if (!ce_f) begin
      if (we_rise && re_f) begin
        if (cle && !ale)       kind = K_CMD;
        else if (ale && !cle)  kind = K_ADDR;
        else if (!ale && !cle) kind = K_DIN;
      end else if (re_rise && we_f && !cle && !ale) begin
        kind = K_DOUT;
      end
    end
  end

  assert_write_kinds_need_we_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CMD || kind == K_ADDR || kind == K_DIN) |-> $past(we_f) == 1'b0);

endmodule

// File: rtl/nbd_phase_track.sv
module nbd_phase_track
  import nbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cyc_kind_t        kind,
  input  logic [7:0]       io_in,
  input  logic             wp_n,
  input  logic             addr_5b,
  output logic             ev_cmd,
  output logic             ev_addr,
  output logic             ev_din,
  output logic             ev_dout,
  output logic [7:0]       ev_byte,
  output logic [IDX_W-1:0] ev_addr_idx,
  output logic             ev_wp_block,
  output logic             ev_phase_err
);
  logic             cmd_open;
  logic             din_open;
  logic [IDX_W-1:0] addr_cnt;
  logic [IDX_W-1:0] want;

  assign want = addr_len(addr_5b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cmd <= 1'b0; ev_addr <= 1'b0; ev_din <= 1'b0; ev_dout <= 1'b0;
      ev_wp_block <= 1'b0; ev_phase_err <= 1'b0;
      ev_byte <= '0; ev_addr_idx <= '0;
      cmd_open <= 1'b0; din_open <= 1'b0; addr_cnt <= '0;
    end else begin
      ev_cmd <= 1'b0; ev_addr <= 1'b0; ev_din <= 1'b0; ev_dout <= 1'b0;
      ev_wp_block <= 1'b0; ev_phase_err <= 1'b0;
      unique case (kind)
        K_CMD: begin
          addr_cnt <= '0;
          if (is_modify(io_in) && !wp_n) begin
            ev_wp_block <= 1'b1;
            cmd_open    <= 1'b0;
            din_open    <= 1'b0;
          end else begin
            ev_cmd   <= 1'b1;
            ev_byte  <= io_in;
            cmd_open <= 1'b1;
            din_open <= opens_din(io_in);
          end
        end
        K_ADDR: begin
          if (cmd_open && addr_cnt < want) begin
            ev_addr     <= 1'b1;
            ev_byte     <= io_in;
            ev_addr_idx <= addr_cnt;
            addr_cnt    <= addr_cnt + 1'b1;
          end else begin
            ev_phase_err <= 1'b1;
          end
        end
        K_DIN: begin
          if (!wp_n)                             ev_wp_block <= 1'b1;
          else if (din_open && addr_cnt == want) begin
            ev_din  <= 1'b1;
            ev_byte <= io_in;
          end else                               ev_phase_err <= 1'b1;
        end
        K_DOUT: begin
          ev_dout <= 1'b1;
          ev_byte <= '0;
        end
        default: ;
      endcase
    end
  end

  assert_exclusive_events_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_cmd, ev_addr, ev_din, ev_dout, ev_wp_block, ev_phase_err}));

  assert_din_needs_wp_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_din |-> $past(wp_n));

  assert_addr_idx_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |-> ev_addr_idx < addr_len($past(addr_5b)));

  assert_cmd_clears_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd |-> addr_cnt == '0);

endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder
  import nbd_pkg::*;
#(
  parameter int GLITCH_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic             wp_n,
  input  logic [7:0]       io_in,
  input  logic             addr_5b,
  output logic             ev_cmd,
  output logic             ev_addr,
  output logic             ev_din,
  output logic             ev_dout,
  output logic [7:0]       ev_byte,
  output logic [IDX_W-1:0] ev_addr_idx,
  output logic             ev_wp_block,
  output logic             ev_phase_err,
  output logic             dout_oe
);
  localparam int NSTROBE = 3;

  logic [NSTROBE-1:0] strobe_raw;
  logic [NSTROBE-1:0] strobe_f;
  logic               ce_f, we_f, re_f;
  logic               we_rise, re_rise;
  cyc_kind_t          kind;

  assign strobe_raw = {re_n, we_n, ce_n};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_filt
    nbd_deglitch #(.MIN_W(GLITCH_W), .INIT(1'b1)) i_filt (
      .clk (clk),
      .rst_n(rst_n),
      .raw (strobe_raw[g]),
      .filt(strobe_f[g])
    );
  end

  assign ce_f = strobe_f[0];
  assign we_f = strobe_f[1];
  assign re_f = strobe_f[2];

  nbd_cycle_class i_class (
    .clk(clk), .rst_n(rst_n),
    .ce_f(ce_f), .we_f(we_f), .re_f(re_f),
    .cle(cle), .ale(ale),
    .kind(kind), .we_rise(we_rise), .re_rise(re_rise), .dout_oe(dout_oe)
  );

  nbd_phase_track i_track (
    .clk(clk), .rst_n(rst_n),
    .kind(kind), .io_in(io_in), .wp_n(wp_n), .addr_5b(addr_5b),
    .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_din(ev_din), .ev_dout(ev_dout),
    .ev_byte(ev_byte), .ev_addr_idx(ev_addr_idx),
    .ev_wp_block(ev_wp_block), .ev_phase_err(ev_phase_err)
  );

  assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_f) |-> !(ev_cmd || ev_addr || ev_din || ev_dout));

  assert_deselect_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_f |-> !dout_oe);

endmodule

// File: tb/test_nand_bus_decoder.sv
module test_nand_bus_decoder;
  localparam int W = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic       addr_5b = 1'b0;
  logic       ev_cmd, ev_addr, ev_din, ev_dout, ev_wp_block, ev_phase_err, dout_oe;
  logic [7:0] ev_byte;
  logic [2:0] ev_addr_idx;

  int n_cmp = 0, n_bad = 0;
  int n_cmd = 0, n_addr = 0, n_din = 0, n_dout = 0, n_blk = 0, n_err = 0;
  int last_byte = 0, last_idx = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nand_bus_decoder #(.GLITCH_W(W)) i_nand_bus_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .addr_5b(addr_5b),
    .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_din(ev_din), .ev_dout(ev_dout),
    .ev_byte(ev_byte), .ev_addr_idx(ev_addr_idx), .ev_wp_block(ev_wp_block),
    .ev_phase_err(ev_phase_err), .dout_oe(dout_oe)
  );

  always @(posedge clk) begin
    if (ev_cmd)       n_cmd  <= n_cmd + 1;
    if (ev_addr)      n_addr <= n_addr + 1;
    if (ev_din)       n_din  <= n_din + 1;
    if (ev_dout)      n_dout <= n_dout + 1;
    if (ev_wp_block)  n_blk  <= n_blk + 1;
    if (ev_phase_err) n_err  <= n_err + 1;
    if (ev_cmd || ev_addr || ev_din) last_byte <= int'(ev_byte);
    if (ev_addr) last_idx <= int'(ev_addr_idx);
  end

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (W + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cycle(input logic c, input logic a, input logic [7:0] b);
    cle = c; ale = a; io_in = b;
    settle();
    we_n = 1'b0;
    settle();
    we_n = 1'b1;
    settle();
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic fill_addr(input int n);
    for (int i = 0; i < n; i++) wr_cycle(1'b0, 1'b1, 8'(8'h40 + i));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int c0, a0, d0, o0, b0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset dout_oe", int'(dout_oe), 0);
    check("R1 reset events", int'({ev_cmd, ev_addr, ev_din, ev_dout, ev_wp_block, ev_phase_err}), 0);

    // R9: deselected, a command strobe yields nothing
    c0 = n_cmd; e0 = n_err;
    wr_cycle(1'b1, 1'b0, 8'h00);
    check("R9 no cmd while deselected", n_cmd - c0, 0);
    check("R9 no err while deselected", n_err - e0, 0);
    re_n = 1'b0; settle();
    check("R9 dout_oe while deselected", int'(dout_oe), 0);
    re_n = 1'b1; settle();

    ce_n = 1'b0; settle();

    // R1: plain command, and both latches high
    c0 = n_cmd;
    wr_cycle(1'b1, 1'b0, 8'h00);
    check("R1 cmd count", n_cmd - c0, 1);
    check("R1 cmd byte", last_byte, 0);
    c0 = n_cmd; a0 = n_addr; e0 = n_err; d0 = n_din;
    wr_cycle(1'b1, 1'b1, 8'h33);
    check("R1 both latches silent", (n_cmd - c0) + (n_addr - a0) + (n_err - e0) + (n_din - d0), 0);

    // R2 / R8: address windows in both modes
    for (int m = 0; m < 2; m++) begin
      int n;
      addr_5b = m[0];
      n = m ? 5 : 4;
      wr_cycle(1'b1, 1'b0, 8'h80);
      for (int i = 0; i < n; i++) begin
        a0 = n_addr;
        wr_cycle(1'b0, 1'b1, 8'(8'hA0 + 8'(i)));
        check("R2 addr event", n_addr - a0, 1);
        check("R2 addr index", last_idx, i);
        check("R2 addr byte", last_byte, 8'hA0 + i);
      end
      a0 = n_addr; e0 = n_err;
      wr_cycle(1'b0, 1'b1, 8'hEE);
      check("R8 extra addr rejected", n_addr - a0, 0);
      check("R8 extra addr error", n_err - e0, 1);
      // R3: data sweep in the open phase
      for (int k = 0; k < 6; k++) begin
        d0 = n_din;
        wr_cycle(1'b0, 1'b0, 8'((k * 37 + m * 11) & 255));
        check("R3 din event", n_din - d0, 1);
        check("R3 din byte", last_byte, (k * 37 + m * 11) & 255);
      end
    end
    addr_5b = 1'b0;

    // R5: write protect blocks modify commands only
    wp_n = 1'b0;
    c0 = n_cmd; b0 = n_blk;
    wr_cycle(1'b1, 1'b0, 8'h60);
    check("R5 erase blocked no cmd", n_cmd - c0, 0);
    check("R5 erase blocked pulse", n_blk - b0, 1);
    e0 = n_err; a0 = n_addr;
    wr_cycle(1'b0, 1'b1, 8'h01);
    check("R5 blocked cmd closes op", n_err - e0, 1);
    c0 = n_cmd;
    wr_cycle(1'b1, 1'b0, 8'h90);
    check("R5 non-modify passes", n_cmd - c0, 1);

    // R6: protect pulse with no write strobe has no lasting effect
    wp_n = 1'b0; settle(); wp_n = 1'b1; settle();
    c0 = n_cmd;
    wr_cycle(1'b1, 1'b0, 8'h80);
    check("R6 cmd after released protect", n_cmd - c0, 1);
    fill_addr(4);
    wp_n = 1'b0;
    d0 = n_din; b0 = n_blk;
    wr_cycle(1'b0, 1'b0, 8'h5A);
    check("R6 late protect blocks data", n_din - d0, 0);
    check("R6 late protect pulse", n_blk - b0, 1);
    wp_n = 1'b1;
    d0 = n_din;
    wr_cycle(1'b0, 1'b0, 8'hA5);
    check("R6 data after release", n_din - d0, 1);

    // R11: data outside its phase
    wr_cycle(1'b1, 1'b0, 8'h00);
    fill_addr(4);
    d0 = n_din; e0 = n_err;
    wr_cycle(1'b0, 1'b0, 8'h11);
    check("R11 data after read cmd", n_err - e0, 1);
    check("R11 no din after read cmd", n_din - d0, 0);
    wr_cycle(1'b1, 1'b0, 8'h85);
    fill_addr(2);
    e0 = n_err;
    wr_cycle(1'b0, 1'b0, 8'h22);
    check("R11 data before window full", n_err - e0, 1);

    // R10: new command restarts the address count
    wr_cycle(1'b1, 1'b0, 8'h80);
    fill_addr(3);
    wr_cycle(1'b1, 1'b0, 8'h85);
    wr_cycle(1'b0, 1'b1, 8'h77);
    check("R10 index after new cmd", last_idx, 0);

    // R4: read beats
    o0 = n_dout;
    re_n = 1'b0; settle();
    check("R4 oe during read low", int'(dout_oe), 1);
    re_n = 1'b1; settle();
    check("R4 dout beat", n_dout - o0, 1);
    check("R4 oe after read", int'(dout_oe), 0);
    cle = 1'b1; o0 = n_dout;
    re_n = 1'b0; settle(); re_n = 1'b1; settle();
    cle = 1'b0;
    check("R4 no beat with latch high", n_dout - o0, 0);

    // R7: short pulses ignored on each strobe
    c0 = n_cmd;
    cle = 1'b1; io_in = 8'h00; settle();
    we_n = 1'b0; repeat (W - 1) @(negedge clk); we_n = 1'b1; settle();
    cle = 1'b0;
    check("R7 short we pulse dropped", n_cmd - c0, 0);
    o0 = n_dout;
    re_n = 1'b0; repeat (W - 1) @(negedge clk); re_n = 1'b1; settle();
    check("R7 short re pulse dropped", n_dout - o0, 0);
    c0 = n_cmd;
    cle = 1'b1; io_in = 8'h70; settle();
    we_n = 1'b0; settle();
    ce_n = 1'b1; repeat (W - 1) @(negedge clk); ce_n = 1'b0;
    we_n = 1'b1;
    repeat (W) @(posedge clk); #1;
    check("R7 event not yet", int'(ev_cmd), 0);
    @(posedge clk); #1;
    check("R7 event at W+1", int'(ev_cmd), 1);
    @(negedge clk); cle = 1'b0; settle();
    check("R7 short ce pulse dropped", n_cmd - c0, 1);

    finish_run();
  end
endmodule